// File: doc/BRIEF.md
# Four-phase fetch-execute sequencer

This block sets the timing and program flow of a small accumulator-based core. A two-bit phase register turns the system clock into four strobes, T1 to T4. Exactly one strobe is high on every system clock, and each full pass through the four strobes is one instruction cycle. The block holds the program counter and presents it as the fetch address for the whole of an instruction cycle. At the clock edge that closes T4, the block loads the word returned by program memory into the execute stage. On that same edge it advances the counter.

The core therefore runs a two-stage overlapped pipeline: while the decoder works on the held instruction during T2 to T4, the next word is being fetched. Decode logic requests a branch by raising a request with a target address during T4 of a cycle that executes a real instruction. The target is loaded into the counter at the next T1. The sequential word fetched during the jump's own cycle is replaced by a no-operation bubble, so a taken branch costs one extra instruction cycle. A "retired" pulse marks T4 of every cycle that executes a real instruction.

Top module: `fx_sequencer`

## Requirements
- R1: `phase_o` is one-hot on every clock, with bit 0 = T1 and bit 3 = T4, and advances T1, T2, T3, T4, then T1 again.
- R2: While `rst_ni` is low, and in the first cycle after it rises: `phase_o` = 4'b0001, `fetch_addr_o` = 0, `exec_instr_o` = NOP_WORD (default 0), `bubble_o` = 1 and `retire_o` = 0.
- R3: `fetch_addr_o` stays constant through T1 to T4 and changes only on the edge that closes T4. With no taken branch it becomes the old value plus one, modulo 2^PC_W.
- R4: The `instr_i` value present on the edge that closes T4 is shown on `exec_instr_o`, with `bubble_o` = 0, for the whole next instruction cycle, unless that edge takes a branch.
- R5: A branch is taken when `branch_req_i` is high during T4 of a cycle with `bubble_o` = 0. The next cycle then fetches from `branch_tgt_i`, and its execute stage holds NOP_WORD with `bubble_o` = 1, so the jump takes two instruction cycles.
- R6: `branch_req_i` has no effect during T1, T2 or T3.
- R7: `branch_req_i` has no effect in a cycle where `bubble_o` = 1: the fetch address still steps by one.
- R8: `retire_o` is high for exactly one clock, T4, of each cycle with `bubble_o` = 0, and low in every other clock.
- R9: A branch to the highest address 2^PC_W-1 is followed by a sequential fetch from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | INSTR_W | Word read from program memory at `fetch_addr_o` |
| branch_req_i | input | 1 | Branch request from the decode logic, sampled in T4 |
| branch_tgt_i | input | PC_W | Branch target address |
| fetch_addr_o | output | PC_W | Program counter / fetch address |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = T1 |
| exec_instr_o | output | INSTR_W | Instruction in the execute stage |
| bubble_o | output | 1 | Execute stage holds a bubble (reset fill or branch flush) |
| retire_o | output | 1 | A real instruction completes in this T4 |

## Verification
The assertions check these rules on every cycle:
- the phase stays one-hot and steps in order;
- the counter is held between T4 edges and either steps by one or takes the target;
- the execute stage loads only at T4, and a taken branch always leaves a bubble behind it;
- a request during a bubble cannot redirect the counter;
- retire pulses are never wider than one clock.

Only the bench's scenarios can show the whole story end to end: which address each cycle actually fetches, that the word shown in execute is the one fetched one cycle earlier, that a jump costs exactly two cycles, and that the counter wraps to zero after the top address. They also show that requests in T1 to T3 are ignored and that a reset in the middle of a cycle restarts cleanly.

// File: rtl/fx_seq_pkg.sv
`timescale 1ns/1ps
package fx_seq_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PHASE_W    = $clog2(NUM_PHASES);

  typedef enum logic [PHASE_W-1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;
endpackage

// File: rtl/fx_phase_gen.sv
`timescale 1ns/1ps
module fx_phase_gen
  import fx_seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output phase_e                phase_o,
  output logic [NUM_PHASES-1:0] strobe_o,
  output logic                  last_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_T1;
    else         phase_q <= phase_e'(phase_q + 1'b1);
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
    assign strobe_o[g] = (phase_q == phase_e'(g));
  end

  assign phase_o = phase_q;
  assign last_o  = strobe_o[NUM_PHASES-1];

  assert_phase_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_o == PH_T1));
  assert_phase_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> !strobe_o[0]);
endmodule

// File: rtl/fx_pc_unit.sv
`timescale 1ns/1ps
module fx_pc_unit #(
  parameter int unsigned PC_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,   // edge closing T4
  input  logic            take_i,  // taken branch on this edge
  input  logic [PC_W-1:0] tgt_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (adv_i)   pc_q <= take_i ? tgt_i : pc_q + PC_ONE;
  end

  assign pc_o = pc_q;

  assert_pc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pc_o));
  assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !take_i |=> pc_o == $past(pc_o) + PC_ONE);
  assert_pc_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && take_i |=> pc_o == $past(tgt_i));
endmodule

// File: rtl/fx_exec_stage.sv
`timescale 1ns/1ps
module fx_exec_stage #(
  parameter int unsigned       INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               squash_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               valid_o
);
  logic [INSTR_W-1:0] instr_q;
  logic               valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= NOP_WORD;
      valid_q <= 1'b0;
    end else if (load_i) begin
      instr_q <= squash_i ? NOP_WORD : instr_i;
      valid_q <= !squash_i;
    end
  end

  assign instr_o = instr_q;
  assign valid_o = valid_q;

  assert_exec_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(instr_o) && $stable(valid_o));
  assert_exec_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !squash_i |=> valid_o && instr_o == $past(instr_i));
  assert_exec_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && squash_i |=> !valid_o && instr_o == NOP_WORD);
endmodule

// File: rtl/fx_sequencer.sv
`timescale 1ns/1ps
module fx_sequencer
  import fx_seq_pkg::*;
#(
  parameter int unsigned        PC_W     = 10,
  parameter int unsigned        INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [INSTR_W-1:0]    instr_i,
  input  logic                  branch_req_i,
  input  logic [PC_W-1:0]       branch_tgt_i,
  output logic [PC_W-1:0]       fetch_addr_o,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic [INSTR_W-1:0]    exec_instr_o,
  output logic                  bubble_o,
  output logic                  retire_o
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  phase_e phase;
  logic   cyc_end;
  logic   exec_valid;
  logic   take;

  fx_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_o  (phase),
    .strobe_o (phase_o),
    .last_o   (cyc_end)
  );

  // only a live instruction in T4 may redirect the counter
  assign take = cyc_end & branch_req_i & exec_valid;

  fx_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (cyc_end),
    .take_i (take),
    .tgt_i  (branch_tgt_i),
    .pc_o   (fetch_addr_o)
  );

  fx_exec_stage #(.INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_exec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cyc_end),
    .squash_i (take),
    .instr_i  (instr_i),
    .instr_o  (exec_instr_o),
    .valid_o  (exec_valid)
  );

  assign bubble_o = !exec_valid;
  assign retire_o = cyc_end & exec_valid;

  assert_phase_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(phase_o));
  assert_retire_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
  assert_bubble_no_redirect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[NUM_PHASES-1] && bubble_o |=> fetch_addr_o == $past(fetch_addr_o) + PC_ONE);
  assert_early_req_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[NUM_PHASES-1] |=> $stable(fetch_addr_o) && $stable(bubble_o));
endmodule

// File: tb/sim_fx_sequencer.sv
`timescale 1ns/1ps
module sim_fx_sequencer;
  localparam int unsigned PC_W    = 10;
  localparam int unsigned INSTR_W = 16;
  localparam logic [INSTR_W-1:0] NOP = '0;

  typedef struct packed {
    logic            req;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] addr;
    logic            bub;
    logic [PC_W-1:0] xaddr;
  } vec_t;

  // one entry per instruction cycle after reset
  localparam vec_t VEC [12] = '{
    '{1'b1, 10'd100,  10'd0,    1'b1, 10'd0},    // R7 req during reset bubble
    '{1'b0, 10'd0,    10'd1,    1'b0, 10'd0},
    '{1'b1, 10'd80,   10'd2,    1'b0, 10'd1},    // R5 jump
    '{1'b0, 10'd0,    10'd80,   1'b1, 10'd0},
    '{1'b0, 10'd0,    10'd81,   1'b0, 10'd80},
    '{1'b1, 10'd1023, 10'd82,   1'b0, 10'd81},   // R9 jump to top
    '{1'b0, 10'd0,    10'd1023, 1'b1, 10'd0},
    '{1'b0, 10'd0,    10'd0,    1'b0, 10'd1023},
    '{1'b1, 10'd5,    10'd1,    1'b0, 10'd0},
    '{1'b1, 10'd200,  10'd5,    1'b1, 10'd0},    // R7 req in flush bubble
    '{1'b0, 10'd0,    10'd6,    1'b0, 10'd5},
    '{1'b0, 10'd0,    10'd7,    1'b0, 10'd6}
  };

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [INSTR_W-1:0] instr;
  logic               breq = 1'b0;
  logic [PC_W-1:0]    btgt = '0;
  logic [PC_W-1:0]    fetch_addr;
  logic [3:0]         phase;
  logic [INSTR_W-1:0] exec_instr;
  logic               bubble;
  logic               retire;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [INSTR_W-1:0] enc(input logic [PC_W-1:0] a);
    return {6'b101101, a};
  endfunction

  assign instr = enc(fetch_addr);

  fx_sequencer #(.PC_W(PC_W), .INSTR_W(INSTR_W), .NOP_WORD(NOP)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .instr_i      (instr),
    .branch_req_i (breq),
    .branch_tgt_i (btgt),
    .fetch_addr_o (fetch_addr),
    .phase_o      (phase),
    .exec_instr_o (exec_instr),
    .bubble_o     (bubble),
    .retire_o     (retire)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " phase"},  32'(phase), 32'h1);
    check({tag, " addr"},   32'(fetch_addr), 32'h0);
    check({tag, " exec"},   32'(exec_instr), 32'(NOP));
    check({tag, " bubble"}, 32'(bubble), 32'h1);
    check({tag, " retire"}, 32'(retire), 32'h0);
  endtask

  // one instruction cycle, starting at T1 between edges
  task automatic run_cycle(input logic req, input logic [PC_W-1:0] tgt,
                           input logic [PC_W-1:0] e_addr, input logic e_bub,
                           input logic [PC_W-1:0] e_x, input logic req_early);
    for (int p = 0; p < 4; p++) begin
      check("R1 phase", 32'(phase), 32'(1 << p));
      check("R3 addr stable", 32'(fetch_addr), 32'(e_addr));
      if (p == 0 || p == 3) begin
        check("R4 exec word", 32'(exec_instr), e_bub ? 32'(NOP) : 32'(enc(e_x)));
        check("R5 bubble", 32'(bubble), 32'(e_bub));
      end
      check("R8 retire", 32'(retire), 32'((p == 3) && !e_bub));
      breq = (p == 3) ? req : req_early;
      btgt = tgt;
      @(negedge clk);
    end
    breq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R2 in reset");
    rst_ni = 1'b1;
    check_reset_state("R2 after release");

    for (int i = 0; i < 12; i++)
      run_cycle(VEC[i].req, VEC[i].tgt, VEC[i].addr, VEC[i].bub, VEC[i].xaddr, 1'b0);

    // R6: request held in T1..T3 only, dropped for T4
    run_cycle(1'b0, 10'd300, 10'd8, 1'b0, 10'd7, 1'b1);
    run_cycle(1'b0, 10'd0,   10'd9, 1'b0, 10'd8, 1'b0);

    // R2: asynchronous reset in the middle of a cycle
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R2 mid-cycle reset");
    @(negedge clk);
    rst_ni = 1'b1;
    run_cycle(1'b0, 10'd0, 10'd0, 1'b1, 10'd0, 1'b0);
    run_cycle(1'b0, 10'd0, 10'd1, 1'b0, 10'd0, 1'b0);

    finish_run();
  end
endmodule